// File: doc/BRIEF.md
# Periodic Schedule Frame-Span Node Walker

This block sits inside the periodic-schedule walker of a USB host controller and picks the address of the next schedule node to fetch. Each cycle it may be shown one decoded node: whether it is a frame-span traversal node (FSTN), its normal link pointer and its back link pointer, each with a terminate bit. From these it moves a cursor along the schedule. A micro-frame start strobe restarts the cursor at the frame-list entry.

An FSTN whose back link has its terminate bit clear marks a place to save. When one is met early in the frame, the walker stores that node's normal pointer and detours along the back link into a recovery path that belongs to an earlier frame. While it is on that detour, start-split transactions are held off. An FSTN whose back terminate bit is set marks the point to restore. When the walker meets one in recovery, it returns to the stored pointer. If time runs short during recovery, the detour is dropped and the walk for the micro-frame ends.

Fetching memory, parsing descriptors and running bus transactions are left to neighbouring logic. That logic fetches from `next_addr` and presents the resulting node on the node inputs.

Top module: `fstn_walker`

## Requirements
- R1: After reset, `next_addr` is 0, `walk_done` is 0, `recovery_active` is 0 and `ssplit_block` is 0. The latched micro-frame class is "late" until the first start strobe.
- R2: One cycle after `uframe_start`, `next_addr` holds the aligned `frame_entry_ptr`, and `walk_done` and `recovery_active` are 0. The strobe overrides every other input in that cycle. The strobe also latches whether `uframe_idx` is 0 or 1 ("early").
- R3: An accepted FSTN with `back_t`=0 (save place), seen in an early micro-frame while not in recovery, stores the aligned `norm_ptr`. One cycle later, `next_addr` is the aligned `back_ptr` and `recovery_active` is 1.
- R4: `ssplit_block` is 1 exactly when `recovery_active` is 1.
- R5: An accepted FSTN with `back_t`=1 (restore), seen while in recovery, sets `next_addr` to the stored pointer and clears `recovery_active`. Its own pointers are ignored.
- R6: A restore FSTN seen while not in recovery sets `next_addr` to its own aligned `norm_ptr`.
- R7: In micro-frames 2 to 7, every FSTN is followed through its aligned `norm_ptr`, and recovery is never entered.
- R8: A save-place FSTN seen while already in recovery is followed through its `norm_ptr` and leaves the stored pointer unchanged.
- R9: An accepted non-FSTN node with `norm_t`=0 sets `next_addr` to its aligned `norm_ptr`. With `norm_t`=1 it sets `walk_done` and leaves `next_addr` unchanged.
- R10: `no_time`=1 while in recovery, without a start strobe, clears `recovery_active` and sets `walk_done`. Outside recovery, `no_time` has no effect.
- R11: The low 5 bits of every pointer are ignored, so `next_addr[4:0]` is always 0.
- R12: While `walk_done` is 1, presented nodes are ignored until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uframe_start | input | 1 | Micro-frame start strobe |
| uframe_idx | input | 3 | Micro-frame index within the frame, sampled with the strobe |
| frame_entry_ptr | input | ADDR_W | Pointer taken from the frame-list entry |
| no_time | input | 1 | Not enough time left in the micro-frame |
| node_valid | input | 1 | A decoded node is presented this cycle |
| node_is_fstn | input | 1 | The presented node is an FSTN |
| norm_ptr | input | ADDR_W | Normal link pointer of the node |
| norm_t | input | 1 | Terminate bit of the normal link |
| back_ptr | input | ADDR_W | Back link pointer of an FSTN |
| back_t | input | 1 | Terminate bit of the back link |
| next_addr | output | ADDR_W | Address of the next node to fetch |
| walk_done | output | 1 | Traversal finished for this micro-frame |
| recovery_active | output | 1 | Walker is on the recovery path |
| ssplit_block | output | 1 | Start-split transactions are inhibited |

## Verification
The hardest case to reach from the ports is a save-place FSTN met while already in recovery, followed by a restore. The stored pointer can only be observed through the address that the later restore produces. The bench reaches this with a directed walk: a strobe for micro-frame 0, a save node, a second save node, and then a restore. It then checks that the first node's normal pointer comes back. Seeded random traffic weights the micro-frame index toward 0 and 1 and often leaves `back_t` clear, so nested saves, restores and `no_time` abandons also occur inside recovery.

// File: rtl/fstn_pkg.sv
package fstn_pkg;
  // What the walker does with the current cycle's inputs
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_FRAME   = 3'd1,
    EV_ABANDON = 3'd2,
    EV_ENTER   = 3'd3,
    EV_RESTORE = 3'd4,
    EV_PASS    = 3'd5,
    EV_END     = 3'd6
  } walk_ev_e;
endpackage

// File: rtl/fstn_classify.sv
module fstn_classify
  import fstn_pkg::*;
(
  input  logic     start_i,
  input  logic     no_time_i,
  input  logic     node_valid_i,
  input  logic     is_fstn_i,
  input  logic     norm_t_i,
  input  logic     back_t_i,
  input  logic     rec_i,
  input  logic     done_i,
  input  logic     early_i,
  output walk_ev_e ev_o
);
  // save-place marker: back link not terminated
  function automatic logic is_save(input logic bt);
    return !bt;
  endfunction

  always_comb begin
    ev_o = EV_NONE;
    if (start_i)                    ev_o = EV_FRAME;
    else if (rec_i && no_time_i)    ev_o = EV_ABANDON;
    else if (!node_valid_i || done_i) ev_o = EV_NONE;
    else if (is_fstn_i) begin
      if (is_save(back_t_i) && early_i && !rec_i) ev_o = EV_ENTER;
      else if (!is_save(back_t_i) && rec_i)       ev_o = EV_RESTORE;
      else                                        ev_o = EV_PASS;
    end else begin
      ev_o = norm_t_i ? EV_END : EV_PASS;
    end
  end
endmodule

// File: rtl/fstn_context.sv
module fstn_context
  import fstn_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned EARLY_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_ev_e          ev_i,
  input  logic [IDX_W-1:0]  uframe_idx_i,
  input  logic [ADDR_W-1:0] norm_ptr_i,
  output logic              rec_o,
  output logic              early_o,
  output logic [ADDR_W-1:0] saved_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_W) - 64'd1);

  function automatic logic [ADDR_W-1:0] align_ptr(input logic [ADDR_W-1:0] p);
    return p & ~LOW_MASK;
  endfunction

  logic rec_q, early_q;
  logic [ADDR_W-1:0] saved_q;
  logic clears_rec;
  assign clears_rec = (ev_i == EV_FRAME) || (ev_i == EV_ABANDON) || (ev_i == EV_RESTORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q   <= 1'b0;
      early_q <= 1'b0;
      saved_q <= '0;
    end else begin
      if (ev_i == EV_FRAME) early_q <= (uframe_idx_i < IDX_W'(EARLY_N));
      if (ev_i == EV_ENTER) begin
        rec_q   <= 1'b1;
        saved_q <= align_ptr(norm_ptr_i);
      end else if (clears_rec) begin
        rec_q <= 1'b0;
      end
    end
  end

  assign rec_o   = rec_q;
  assign early_o = early_q;
  assign saved_o = saved_q;

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i == EV_ENTER |=> rec_q);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clears_rec |=> !rec_q);
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_q && ev_i != EV_FRAME) |=> $stable(saved_q));
  p_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !early_q |-> !rec_q);
endmodule

// File: rtl/fstn_cursor.sv
module fstn_cursor
  import fstn_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_ev_e          ev_i,
  input  logic [ADDR_W-1:0] entry_ptr_i,
  input  logic [ADDR_W-1:0] norm_ptr_i,
  input  logic [ADDR_W-1:0] back_ptr_i,
  input  logic [ADDR_W-1:0] saved_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_W) - 64'd1);

  function automatic logic [ADDR_W-1:0] align_ptr(input logic [ADDR_W-1:0] p);
    return p & ~LOW_MASK;
  endfunction

  logic [ADDR_W-1:0] next_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (ev_i)
        EV_FRAME: begin
          next_q <= align_ptr(entry_ptr_i);
          done_q <= 1'b0;
        end
        EV_ABANDON: done_q <= 1'b1;
        EV_ENTER:   next_q <= align_ptr(back_ptr_i);
        EV_RESTORE: next_q <= saved_i;
        EV_PASS:    next_q <= align_ptr(norm_ptr_i);
        EV_END:     done_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign next_o = next_q;
  assign done_o = done_q;

  p_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (next_q & LOW_MASK) == '0);
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i == EV_END |=> done_q);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ev_i == EV_NONE) |=> ($stable(next_q) && done_q));
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i == EV_FRAME |=> !done_q);
endmodule

// File: rtl/fstn_walker.sv
module fstn_walker
  import fstn_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned EARLY_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_start,
  input  logic [IDX_W-1:0]  uframe_idx,
  input  logic [ADDR_W-1:0] frame_entry_ptr,
  input  logic              no_time,
  input  logic              node_valid,
  input  logic              node_is_fstn,
  input  logic [ADDR_W-1:0] norm_ptr,
  input  logic              norm_t,
  input  logic [ADDR_W-1:0] back_ptr,
  input  logic              back_t,
  output logic [ADDR_W-1:0] next_addr,
  output logic              walk_done,
  output logic              recovery_active,
  output logic              ssplit_block
);
  walk_ev_e          ev;
  logic              rec, early, done;
  logic [ADDR_W-1:0] saved;

  fstn_classify u_classify (
    .start_i(uframe_start), .no_time_i(no_time), .node_valid_i(node_valid),
    .is_fstn_i(node_is_fstn), .norm_t_i(norm_t), .back_t_i(back_t),
    .rec_i(rec), .done_i(done), .early_i(early), .ev_o(ev)
  );

  fstn_context #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .EARLY_N(EARLY_N)) u_context (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .uframe_idx_i(uframe_idx),
    .norm_ptr_i(norm_ptr), .rec_o(rec), .early_o(early), .saved_o(saved)
  );

  fstn_cursor #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .entry_ptr_i(frame_entry_ptr),
    .norm_ptr_i(norm_ptr), .back_ptr_i(back_ptr), .saved_i(saved),
    .next_o(next_addr), .done_o(done)
  );

  assign walk_done       = done;
  assign recovery_active = rec;
  assign ssplit_block    = rec;

  // R10: outside recovery the time indication must not end the walk by itself
  p_notime_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (no_time && !rec && !uframe_start && !node_valid && !done) |=> !done);
endmodule

// File: tb/test_fstn_walker.sv
module test_fstn_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uframe_start = 1'b0;
  logic [2:0] uframe_idx = '0;
  logic [AW-1:0] frame_entry_ptr = '0;
  logic no_time = 1'b0, node_valid = 1'b0, node_is_fstn = 1'b0;
  logic [AW-1:0] norm_ptr = '0, back_ptr = '0;
  logic norm_t = 1'b0, back_t = 1'b0;
  logic [AW-1:0] next_addr;
  logic walk_done, recovery_active, ssplit_block;

  always #(CLK_PERIOD/2) clk = ~clk;

  fstn_walker i_fstn_walker (
    .clk(clk), .rst_n(rst_n), .uframe_start(uframe_start), .uframe_idx(uframe_idx),
    .frame_entry_ptr(frame_entry_ptr), .no_time(no_time), .node_valid(node_valid),
    .node_is_fstn(node_is_fstn), .norm_ptr(norm_ptr), .norm_t(norm_t),
    .back_ptr(back_ptr), .back_t(back_t), .next_addr(next_addr),
    .walk_done(walk_done), .recovery_active(recovery_active), .ssplit_block(ssplit_block)
  );

  int n_checks = 0, n_fail = 0, cycles = 0;

  // bench reference state
  logic [AW-1:0] m_next = '0, m_saved = '0;
  logic m_done = 1'b0, m_rec = 1'b0, m_early = 1'b0;
  string m_tag = "R1";

  function automatic logic [AW-1:0] strip(input logic [AW-1:0] p);
    return {p[AW-1:5], 5'b00000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check(next_addr === m_next, m_tag, next_addr, m_next);
    check(walk_done === m_done, {m_tag, " done"}, AW'(walk_done), AW'(m_done));
    check(recovery_active === m_rec, {m_tag, " rec"}, AW'(recovery_active), AW'(m_rec));
    check(ssplit_block === m_rec, "R4 ssplit", AW'(ssplit_block), AW'(m_rec));
    check(next_addr[4:0] === 5'd0, "R11 align", AW'(next_addr[4:0]), '0);
  endtask

  // model update from the values present at the clock edge
  task automatic model_step();
    if (uframe_start) begin
      m_next = strip(frame_entry_ptr); m_done = 0; m_rec = 0;
      m_early = (uframe_idx < 3'd2); m_tag = "R2";
    end else if (m_rec && no_time) begin
      m_rec = 0; m_done = 1; m_tag = "R10";
    end else if (!node_valid || m_done) begin
      m_tag = m_done ? "R12" : "R10 idle";
    end else if (node_is_fstn) begin
      if (!back_t && m_early && !m_rec) begin
        m_saved = strip(norm_ptr); m_next = strip(back_ptr); m_rec = 1; m_tag = "R3";
      end else if (back_t && m_rec) begin
        m_next = m_saved; m_rec = 0; m_tag = "R5";
      end else begin
        m_next = strip(norm_ptr);
        m_tag = !m_early ? "R7" : (m_rec ? "R8" : "R6");
      end
    end else if (norm_t) begin
      m_done = 1; m_tag = "R9 end";
    end else begin
      m_next = strip(norm_ptr); m_tag = "R9 pass";
    end
  endtask

  task automatic step(input bit st, input logic [2:0] idx, input logic [AW-1:0] ent,
                      input bit nt, input bit nv, input bit fs,
                      input logic [AW-1:0] np, input bit ntb,
                      input logic [AW-1:0] bp, input bit btb);
    uframe_start = st; uframe_idx = idx; frame_entry_ptr = ent; no_time = nt;
    node_valid = nv; node_is_fstn = fs; norm_ptr = np; norm_t = ntb;
    back_ptr = bp; back_t = btb;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    m_tag = "R1";
    compare_all(); // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    // R7: before any strobe the class is late, so a save node passes
    step(0,0,0, 0,1,1, 32'h0000_0A1F,0, 32'h0000_0B00,0);
    // R2 start, micro-frame 0, unaligned entry
    step(1,0,32'h1000_0047, 0,0,0, 0,0, 0,0);
    // R3 save place
    step(0,0,0, 0,1,1, 32'h2000_0011,0, 32'h3000_001F,0);
    // R9 plain node in recovery
    step(0,0,0, 0,1,0, 32'h3100_0000,0, 0,0);
    // R8 nested save keeps context
    step(0,0,0, 0,1,1, 32'h4000_0000,0, 32'h5000_0000,0);
    // R5 restore returns to first saved pointer
    step(0,0,0, 0,1,1, 32'h7777_0000,0, 32'h8888_0000,1);
    // R6 restore outside recovery
    step(0,0,0, 0,1,1, 32'h6000_0033,0, 32'h9000_0000,1);
    // R10 no_time outside recovery has no effect
    step(0,0,0, 1,1,0, 32'h6100_0000,0, 0,0);
    // R9 terminate ends walk, R12 node then ignored
    step(0,0,0, 0,1,0, 32'h6200_0000,1, 0,0);
    step(0,0,0, 0,1,0, 32'h6300_0000,0, 0,0);
    // R7 late micro-frame
    step(1,3'd5,32'h1100_0000, 0,0,0, 0,0, 0,0);
    step(0,0,0, 0,1,1, 32'h1200_0000,0, 32'h1300_0000,0);
    // R10 abandon in recovery
    step(1,3'd1,32'h1400_0000, 0,0,0, 0,0, 0,0);
    step(0,0,0, 0,1,1, 32'h1500_0000,0, 32'h1600_0000,0);
    step(0,0,0, 1,1,1, 32'h1700_0000,0, 32'h1800_0000,1);
    step(0,0,0, 0,1,0, 32'h1900_0000,0, 0,0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] idx;
      idx = ($urandom_range(0,1) == 1) ? 3'($urandom_range(0,1)) : 3'($urandom_range(0,7));
      step(($urandom_range(0,15) == 0), idx, $urandom,
           ($urandom_range(0,19) == 0), ($urandom_range(0,3) != 0),
           ($urandom_range(0,2) == 0), $urandom, ($urandom_range(0,9) == 0),
           $urandom, ($urandom_range(0,2) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule